// File: doc/BRIEF.md
# Configurable asynchronous serial receiver

This block turns a single asynchronous serial line into received characters and a receiver status group. A one-cycle baud tick, at sixteen ticks per bit time and produced elsewhere from a programmable divisor, paces all sampling. The host sets the character format through static inputs:
- a word-length code for 5 to 8 data bits,
- a parity enable,
- an even/odd select,
- a stick-parity select.

The format inputs must not change while a frame is in flight.

A received character is right-aligned in an 8-bit holding register, and a data-ready flag marks it as new. Four error flags record faults on the line: overrun, parity error, framing error and break. Each flag is set by a line event and stays set until the host reads the matching register. The host marks a read of the data register with a one-cycle pulse, and a read of the status register with a separate one-cycle pulse.

The frame state machine has five states:

| State | What it does | Transitions |
|---|---|---|
| ST_IDLE | Waits on the synchronised line for a falling edge. | On a falling edge, to ST_START. |
| ST_START | Counts 8 ticks, then samples the line. | If the line is high, the start is a glitch: back to ST_IDLE. If the line is low, to ST_DATA. |
| ST_DATA | Samples one bit every 16 ticks, LSB first. | After the last data bit, to ST_PARITY if parity is enabled, otherwise to ST_STOP. |
| ST_PARITY | Samples and judges the parity bit after 16 more ticks. | To ST_STOP. |
| ST_STOP | Samples a single stop bit after 16 more ticks and reports the frame. | To ST_IDLE. |

Top module: `serial_rx_core`

## Requirements
- R1: The word-length code selects 00 = 5, 01 = 6, 10 = 7 and 11 = 8 data bits. Data bits arrive LSB first. The character appears on rx_data right-aligned, with the unused upper bits zero.
- R2: The parity mode is decoded from {par_stick, par_even, par_en}. With par_en = 0 no parity bit is expected. 0,0,1 expects odd parity over data plus parity bit. 0,1,1 expects even parity. 1,0,1 expects a constant 1. 1,1,1 expects a constant 0.
- R3: data_ready goes high when a frame completes, and a data read pulse without a completing frame clears it.
- R4: If a frame completes while data_ready is high and no data read accompanies it, then overrun is set and rx_data keeps the old character, discarding the new one. A status read clears overrun and leaves data_ready unchanged.
- R5: parity_err is set when the received parity bit mismatches the expected value and is cleared by a status read.
- R6: frame_err is set when the stop bit is sampled low and is cleared by a status read.
- R7: break_flag is set when every sampled bit of a frame (start, data, parity, stop) is low. frame_err is set with it, a zero character is loaded, and a status read clears both flags.
- R8: A low pulse shorter than half a bit time is rejected: no character, no flag. The next valid frame is received normally.
- R9: When a data read coincides with a frame completing, the new character is loaded, data_ready stays high and no overrun is set. When a status read coincides with an error event, the error flag is set.
- R10: After reset all flags are low and rx_data is zero.
- R11: Only one stop bit is checked. A new start bit directly after a single stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_len | input | 2 | Word-length code (R1) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select / stick value select |
| par_stick | input | 1 | Stick parity select |
| rd_data_pulse | input | 1 | Host read of the data register |
| rd_stat_pulse | input | 1 | Host read of the status register |
| rx_data | output | 8 | Held character, right-aligned |
| data_ready | output | 1 | New character held |
| overrun | output | 1 | Character lost while one was held |
| parity_err | output | 1 | Parity mismatch seen |
| frame_err | output | 1 | Stop bit sampled low |
| break_flag | output | 1 | All-low frame seen |

## Verification
A host read and a frame completion can land in the same clock cycle. This covers a data read racing the load of a new character, and a status read racing a parity error. The bench first measures, at the ports, how many cycles a frame of a given format takes to raise data_ready. It then fires both read pulses at exactly that edge, during a frame with a bad parity bit, while the previous character is still unread. The outcome is judged by three checks: the new character is loaded, overrun stays clear, and parity_err stays set. Clear-wins or read-ignored logic would fail at least one of these checks.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic par_bad;
        logic stop_bad;
        logic line_break;
    } rx_flags_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic rx_fall
);
    logic [STAGES-1:0] pipe;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
            last <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], rx_in};
            last <= pipe[STAGES-1];
        end
    end

    assign rx_s    = pipe[STAGES-1];
    assign rx_fall = last & ~pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 8,
    parameter int LEN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                rx_s,
    input  logic                rx_fall,
    input  logic [LEN_W-1:0]    word_len,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    output logic                frm_done,
    output logic [MAX_BITS-1:0] frm_data,
    output rx_flags_t           frm_flags
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(MAX_BITS);
    localparam int NB_W  = $clog2(MAX_BITS + 1);
    localparam int HALF  = OVS / 2;

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [IDX_W-1:0]     idx_q, idx_d;
    logic [MAX_BITS-1:0]  shreg_q, shreg_d;
    logic                 acc_q, acc_d;
    logic                 zero_q, zero_d;
    logic                 pbad_q, pbad_d;

    logic                 done_d;
    logic [MAX_BITS-1:0]  data_d;
    rx_flags_t            flags_d;

    logic [NB_W-1:0]      nbits;
    logic [IDX_W-1:0]     last_idx;
    logic                 at_half, at_full, exp_par;

    assign nbits    = NB_W'(MIN_BITS) + NB_W'(word_len);
    assign last_idx = IDX_W'(nbits - NB_W'(1));
    assign at_half  = baud_tick && (cnt_q == CNT_W'(HALF - 1));
    assign at_full  = baud_tick && (cnt_q == CNT_W'(OVS - 1));
    assign exp_par  = par_stick ? ~par_even : (acc_q ^ ~par_even);

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        shreg_d = shreg_q;
        acc_d   = acc_q;
        zero_d  = zero_q;
        pbad_d  = pbad_q;
        done_d  = 1'b0;
        data_d  = '0;
        flags_d = '0;
        if (state_q != ST_IDLE && baud_tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
        unique case (state_q)
            ST_IDLE: begin
                if (rx_fall) begin
                    state_d = ST_START;
                    cnt_d   = '0;
                    idx_d   = '0;
                    shreg_d = '0;
                    acc_d   = 1'b0;
                    zero_d  = 1'b1;
                    pbad_d  = 1'b0;
                end
            end
            ST_START: begin
                if (at_half) begin
                    cnt_d   = '0;
                    state_d = rx_s ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (at_full) begin
                    cnt_d   = '0;
                    shreg_d = {rx_s, shreg_q[MAX_BITS-1:1]};
                    acc_d   = acc_q ^ rx_s;
                    zero_d  = zero_q & ~rx_s;
                    if (idx_q == last_idx) begin
                        idx_d   = '0;
                        state_d = par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (at_full) begin
                    cnt_d   = '0;
                    pbad_d  = (rx_s != exp_par);
                    zero_d  = zero_q & ~rx_s;
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (at_full) begin
                    cnt_d              = '0;
                    done_d             = 1'b1;
                    data_d             = shreg_q >> (NB_W'(MAX_BITS) - nbits);
                    flags_d.par_bad    = pbad_q;
                    flags_d.stop_bad   = ~rx_s;
                    flags_d.line_break = zero_q & ~rx_s;
                    state_d            = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            acc_q   <= 1'b0;
            zero_q  <= 1'b1;
            pbad_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            shreg_q <= shreg_d;
            acc_q   <= acc_d;
            zero_q  <= zero_d;
            pbad_q  <= pbad_d;
        end
    end

    // registered frame report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_done  <= 1'b0;
            frm_data  <= '0;
            frm_flags <= '0;
        end else begin
            frm_done  <= done_d;
            frm_data  <= data_d;
            frm_flags <= flags_d;
        end
    end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done,
    input  logic [DATA_W-1:0] frm_data,
    input  rx_flags_t         frm_flags,
    input  logic              rd_data_pulse,
    input  logic              rd_stat_pulse,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun,
    output logic              parity_err,
    output logic              frame_err,
    output logic              break_flag
);
    logic lose_char;

    assign lose_char = frm_done && data_ready && !rd_data_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
        end else if (frm_done) begin
            if (!lose_char) begin
                rx_data    <= frm_data;
                data_ready <= 1'b1;
            end
        end else if (rd_data_pulse) begin
            data_ready <= 1'b0;
        end
    end

    // event sets take priority over status-read clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun    <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            break_flag <= 1'b0;
        end else begin
            if (lose_char)                      overrun    <= 1'b1;
            else if (rd_stat_pulse)             overrun    <= 1'b0;
            if (frm_done && frm_flags.par_bad)  parity_err <= 1'b1;
            else if (rd_stat_pulse)             parity_err <= 1'b0;
            if (frm_done && frm_flags.stop_bad) frame_err  <= 1'b1;
            else if (rd_stat_pulse)             frame_err  <= 1'b0;
            if (frm_done && frm_flags.line_break) break_flag <= 1'b1;
            else if (rd_stat_pulse)             break_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int MIN_BITS    = 5,
    parameter int MAX_BITS    = 8,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                rx_in,
    input  logic [LEN_W-1:0]    word_len,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    input  logic                rd_data_pulse,
    input  logic                rd_stat_pulse,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                data_ready,
    output logic                overrun,
    output logic                parity_err,
    output logic                frame_err,
    output logic                break_flag
);
    logic                rx_s, rx_fall;
    logic                frm_done;
    logic [MAX_BITS-1:0] frm_data;
    rx_flags_t           frm_flags;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_in   (rx_in),
        .rx_s    (rx_s),
        .rx_fall (rx_fall)
    );

    rx_frame_fsm #(
        .OVS      (OVS),
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .rx_s      (rx_s),
        .rx_fall   (rx_fall),
        .word_len  (word_len),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_flags (frm_flags)
    );

    rx_status_regs #(.DATA_W(MAX_BITS)) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .frm_done      (frm_done),
        .frm_data      (frm_data),
        .frm_flags     (frm_flags),
        .rd_data_pulse (rd_data_pulse),
        .rd_stat_pulse (rd_stat_pulse),
        .rx_data       (rx_data),
        .data_ready    (data_ready),
        .overrun       (overrun),
        .parity_err    (parity_err),
        .frame_err     (frame_err),
        .break_flag    (break_flag)
    );
endmodule

// File: rtl/rx_core_chk.sv
module rx_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_done,
    input logic              rd_data_pulse,
    input logic              rd_stat_pulse,
    input logic [DATA_W-1:0] rx_data,
    input logic              data_ready,
    input logic              overrun,
    input logic              parity_err,
    input logic              frame_err,
    input logic              break_flag
);
    a_r3_ready_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> data_ready);

    a_r3_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_pulse && !frm_done) |=> !data_ready);

    a_r4_old_char_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && data_ready && !rd_data_pulse) |=> (overrun && $stable(rx_data)));

    // R5, R6, R7 clears on a status read
    a_r5_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_pulse && !frm_done) |=> (!parity_err && !frame_err && !break_flag && !overrun));

    a_r7_break_with_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        break_flag |-> frame_err);

    a_r5_parity_rises_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(frm_done));

    a_r9_no_overrun_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rd_data_pulse && !overrun) |=> !overrun);
endmodule

bind serial_rx_core rx_core_chk #(.DATA_W(MAX_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_done      (frm_done),
    .rd_data_pulse (rd_data_pulse),
    .rd_stat_pulse (rd_stat_pulse),
    .rx_data       (rx_data),
    .data_ready    (data_ready),
    .overrun       (overrun),
    .parity_err    (parity_err),
    .frame_err     (frame_err),
    .break_flag    (break_flag)
);

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
    localparam int TICK_DIV = 3;
    localparam int BITCLK   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       rx_in = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic       rd_data_pulse = 1'b0, rd_stat_pulse = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, overrun, parity_err, frame_err, break_flag;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign baud_tick = (cyc % TICK_DIV) == 0;

    serial_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
        .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .rd_data_pulse(rd_data_pulse), .rd_stat_pulse(rd_stat_pulse),
        .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
        .parity_err(parity_err), .frame_err(frame_err), .break_flag(break_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // mode 0 none, 1 odd, 2 even, 3 stick one, 4 stick zero
    task automatic set_mode(input int wl, input int pm);
        word_len  = 2'(wl);
        par_en    = (pm != 0);
        par_even  = (pm == 2) || (pm == 4);
        par_stick = (pm >= 3);
    endtask

    function automatic logic good_par(input logic [7:0] d, input int pm);
        case (pm)
            1: return ~(^d);
            2: return ^d;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input int n, input bit pen, input bit pbit,
                              input bit stopbit, input int gap, input int pulse_at, output int lat);
        logic [11:0] bits;
        int nb;
        bit seen;
        bits = '0;
        for (int i = 0; i < n; i++) bits[1+i] = d[i];
        nb = 1 + n;
        if (pen) begin bits[nb] = pbit; nb++; end
        bits[nb] = stopbit;
        nb++;
        @(negedge clk);
        while ((cyc % TICK_DIV) != 0) @(negedge clk);
        lat = -1;
        seen = 1'b0;
        for (int k = 0; k < nb * BITCLK + gap; k++) begin
            if (k > 0) @(negedge clk);
            if (!seen && data_ready) begin seen = 1'b1; lat = k; end
            rx_in = (k < nb * BITCLK) ? bits[k / BITCLK] : 1'b1;
            rd_data_pulse = (k == pulse_at);
            rd_stat_pulse = (k == pulse_at);
        end
        @(negedge clk);
        rd_data_pulse = 1'b0;
        rd_stat_pulse = 1'b0;
        rx_in = 1'b1;
    endtask

    task automatic read_data();
        @(negedge clk); rd_data_pulse = 1'b1;
        @(negedge clk); rd_data_pulse = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk); rd_stat_pulse = 1'b1;
        @(negedge clk); rd_stat_pulse = 1'b0;
    endtask

    function automatic logic [7:0] pick(input int j, input int wl, input int pm);
        logic [7:0] base;
        case (j)
            0: base = 8'hA5;
            1: base = 8'h5A;
            2: base = 8'hFF;
            default: base = 8'h00;
        endcase
        return base ^ 8'(wl * 37 + pm * 11);
    endfunction

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat, n, cal;
        logic [7:0] d, mask;
        repeat (4) @(negedge clk);
        chk("R10 rx_data", rx_data, 0);
        chk("R10 flags", {data_ready, overrun, parity_err, frame_err, break_flag}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // sweep word lengths, parity modes, data values, good and bad parity
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 5; pm++) begin
                set_mode(wl, pm);
                n = 5 + wl;
                mask = 8'((1 << n) - 1);
                for (int j = 0; j < 5; j++) begin
                    bit bad;
                    if (j == 4 && pm == 0) continue;
                    bad = (j == 4);
                    d = pick(j % 4, wl, pm) & mask;
                    send_frame(d, n, pm != 0, good_par(d, pm) ^ bad, 1'b1, BITCLK, -1, lat);
                    chk("R1 data", rx_data, d);
                    chk("R3 ready set", data_ready, 1);
                    chk("R2 R5 parity_err", parity_err, bad);
                    chk("R6 frame_err clear", frame_err, 0);
                    chk("R7 break clear", break_flag, 0);
                    chk("R4 overrun clear", overrun, 0);
                    read_data();
                    chk("R3 ready cleared", data_ready, 0);
                    read_stat();
                    chk("R5 parity_err cleared", parity_err, 0);
                end
            end
        end

        // back-to-back frames, second one lost
        set_mode(3, 0);
        send_frame(8'h3C, 8, 0, 0, 1, 0, -1, lat);
        send_frame(8'hC3, 8, 0, 0, 1, BITCLK, -1, lat);
        chk("R11 second frame seen as overrun", overrun, 1);
        chk("R4 old char kept", rx_data, 8'h3C);
        read_stat();
        chk("R4 status read clears overrun", overrun, 0);
        chk("R4 ready kept", data_ready, 1);
        read_data();

        // framing error
        send_frame(8'h55, 8, 0, 0, 0, BITCLK, -1, lat);
        chk("R6 frame_err set", frame_err, 1);
        chk("R6 no break", break_flag, 0);
        chk("R6 data", rx_data, 8'h55);
        read_data();
        read_stat();
        chk("R6 frame_err cleared", frame_err, 0);

        // break
        set_mode(3, 2);
        send_frame(8'h00, 8, 1, 0, 0, BITCLK, -1, lat);
        chk("R7 break set", break_flag, 1);
        chk("R7 frame_err set", frame_err, 1);
        chk("R7 zero char", rx_data, 0);
        read_data();
        read_stat();
        chk("R7 break cleared", {break_flag, frame_err}, 0);

        // glitch
        set_mode(3, 0);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (9) @(negedge clk);
        rx_in = 1'b1;
        repeat (700) @(negedge clk);
        chk("R8 glitch ignored", {data_ready, frame_err, parity_err, break_flag}, 0);
        send_frame(8'h96, 8, 0, 0, 1, BITCLK, -1, lat);
        chk("R8 next frame ok", rx_data, 8'h96);
        read_data();

        // same-cycle reads and completion
        set_mode(3, 2);
        send_frame(8'h0F, 8, 1, good_par(8'h0F, 2), 1, BITCLK, -1, cal);
        chk("R9 latency found", cal > 0, 1);
        read_data();
        read_stat();
        send_frame(8'h11, 8, 1, ~good_par(8'h11, 2), 1, BITCLK, -1, lat);
        send_frame(8'h22, 8, 1, ~good_par(8'h22, 2), 1, BITCLK, cal - 1, lat);
        chk("R9 new char loaded", rx_data, 8'h22);
        chk("R9 ready kept", data_ready, 1);
        chk("R9 no overrun", overrun, 0);
        chk("R9 parity set wins", parity_err, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule